// File: doc/BRIEF.md
# Burst-Capable Flash Read Port

This block is the device side of the read path of a NOR-style flash memory. The host drives active-low strobes for chip enable, output enable, write enable, reset and address valid, plus an address bus. The block returns read data and a WAIT flag. Each of these outputs has its own output-enable signal, so no tristate is needed. The storage array is a synchronous read memory whose contents are a fixed function of the address.

After reset the port performs plain asynchronous reads. A configuration load switches it to synchronous burst reads. A burst has a programmable initial latency and a programmable wrap length. The host stalls a burst with a clock-halt qualifier. If output enable is also dropped, the burst enters a suspend. It picks up where it stopped once output enable returns and the clock runs again. Identifier reads return a single word and keep WAIT asserted.

In synchronous mode the controller moves through five states:
- IDLE waits for an address capture.
- LAT counts down the initial latency.
- BEAT presents burst words.
- INFO holds a single identifier word.
- SUSP freezes a suspended burst.

The transitions are:
- capture: IDLE→LAT, or IDLE→INFO when the identifier space is selected.
- latency done: LAT→BEAT.
- suspend: LAT or BEAT→SUSP.
- resume: SUSP→LAT or SUSP→BEAT.
- recapture: LAT, BEAT or INFO→LAT or INFO.
- standby: any state→IDLE.

Top module: `flash_read_port`

## Requirements
- R1: After reset the port is in asynchronous mode. The state stays IDLE, no burst advances, and WAIT is 0 for array reads.
- R2: In asynchronous mode the address passes through while adv_n is 0 and is held once adv_n is 1. Address changes while adv_n is 1 have no effect on dq_out. dq_out shows the word one clock after the address is taken.
- R3: The array word at address a is the low 16 bits of a*40503, XORed with 0x5A5A.
- R4: In synchronous mode the address is captured on a clock edge where adv_n is 0 and clk_halt is 0. If the clock is halted, the address is instead captured at the edge following the rise of adv_n.
- R5: With latency L, WAIT is 1 after the capture edge. The first burst word appears, with WAIT at 0, after L-1 further clock edges that are not halted.
- R6: The burst wraps linearly inside an aligned block. cfg_len 0 gives 4 words, 1 gives 8 words and 2 gives 16 words.
- R7: While clk_halt is 1 and oe_n is 0, the burst does not advance.
- R8: When clk_halt and oe_n are both 1 during LAT or BEAT, the port enters SUSP. In SUSP dq_oe is 0, wait_oe stays 1 and wait_out holds its value. On resume (oe_n 0, clk_halt 0) the first edge re-presents the same word and the next edge advances.
- R9: When ce_n is 1, dq_oe and wait_oe are 0 in the same cycle, and the state returns to IDLE.
- R10: wait_oe equals !ce_n. dq_oe is 1 only when ce_n is 0, oe_n is 0, we_n is 1 and rst_n is 1.
- R11: A capture with info_sel at 1 returns the single word ID_CODE ^ addr[3:0], with WAIT at 1, and the word does not advance.
- R12: cfg_load sets the mode, the latency and the length. cfg_sync 1 selects burst mode. A latency value below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable (must be 1 for reads) |
| adv_n | input | 1 | Active-low address valid |
| clk_halt | input | 1 | 1 = burst clock halted |
| info_sel | input | 1 | Selects the identifier space at capture |
| addr | input | AW | Word address |
| cfg_load | input | 1 | Loads the read configuration |
| cfg_sync | input | 1 | 1 = synchronous burst mode |
| cfg_lat | input | 3 | Initial latency in clocks (2..7) |
| cfg_len | input | 2 | Burst length select |
| dq_out | output | DW | Read data |
| dq_oe | output | 1 | Data output enable |
| wait_out | output | 1 | WAIT flag, 1 = data not valid |
| wait_oe | output | 1 | WAIT output enable |

## Verification
The assertions check four behaviours on every clock:
- A burst word advances only inside its aligned wrap block.
- A halted clock or a suspend freezes the burst pointer.
- Deselection forces IDLE.
- A resume leaves SUSP, and data is never driven while WAIT is released.

The bench scenarios alone can show that the returned words match the array function and that latency counts edges correctly. They also cover the wrap order for each length, address capture at the adv_n rise, the ignored late address changes, and the return to asynchronous reads after reset.

// File: rtl/flash_read_pkg.sv
package flash_read_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAT,
        ST_BEAT,
        ST_INFO,
        ST_SUSP
    } rd_state_e;
endpackage

// File: rtl/flash_array.sv
module flash_array #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam logic [31:0] MULT = 32'd40503;
    localparam logic [31:0] SEED = 32'h0000_5A5A;

    function automatic logic [DW-1:0] cell_value(input logic [AW-1:0] a);
        logic [31:0] p;
        p = 32'(a) * MULT;
        return DW'(p) ^ DW'(SEED);
    endfunction

    always_ff @(posedge clk) begin
        rd_data <= cell_value(rd_addr);
    end
endmodule

// File: rtl/burst_ptr_next.sv
module burst_ptr_next #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] ptr,
    input  logic [1:0]    len_sel,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] mask;

    always_comb begin
        unique case (len_sel)
            2'd0:    mask = AW'(3);
            2'd1:    mask = AW'(7);
            default: mask = AW'(15);
        endcase
        nxt = (ptr & ~mask) | ((ptr + AW'(1)) & mask);
    end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import flash_read_pkg::*;
#(
    parameter int          AW      = 8,
    parameter logic [2:0]  LAT_RST = 3'd4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          adv_n,
    input  logic          halt,
    input  logic          info_sel,
    input  logic [AW-1:0] addr,
    input  logic          cfg_load,
    input  logic          cfg_sync,
    input  logic [2:0]    cfg_lat,
    input  logic [1:0]    cfg_len,
    output logic [AW-1:0] ptr_d,
    output logic [AW-1:0] ptr_q,
    output logic          info_q,
    output logic          wait_val
);
    rd_state_e     state_q, state_d;
    logic [2:0]    cnt_q, cnt_d;
    logic          armed_q, armed_d;
    logic          susp_lat_q, susp_lat_d;
    logic          info_d;
    logic          sync_q;
    logic [2:0]    lat_q;
    logic [1:0]    len_q;
    logic [AW-1:0] wrap_nxt;
    logic          go;

    burst_ptr_next #(.AW(AW)) ptr_next_i (
        .ptr     (ptr_q),
        .len_sel (len_q),
        .nxt     (wrap_nxt)
    );

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        ptr_d      = ptr_q;
        cnt_d      = cnt_q;
        armed_d    = armed_q;
        susp_lat_d = susp_lat_q;
        info_d     = info_q;
        go         = 1'b0;
        if (ce_n) begin
            state_d = ST_IDLE;
            armed_d = 1'b0;
            info_d  = 1'b0;
        end else if (!sync_q) begin
            state_d = ST_IDLE;
            if (!adv_n) begin
                ptr_d  = addr;
                info_d = info_sel;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!adv_n) begin
                        ptr_d   = addr;
                        info_d  = info_sel;
                        armed_d = 1'b1;
                        go      = !halt;
                    end else if (armed_q) begin
                        go = 1'b1;
                    end
                end
                ST_LAT, ST_BEAT, ST_INFO: begin
                    if (!adv_n && !halt) begin
                        ptr_d  = addr;
                        info_d = info_sel;
                        go     = 1'b1;
                    end else if (halt && oe_n && state_q != ST_INFO) begin
                        state_d    = ST_SUSP;
                        susp_lat_d = (state_q == ST_LAT);
                    end else if (!halt) begin
                        if (state_q == ST_LAT) begin
                            if (cnt_q <= 3'd1) state_d = ST_BEAT;
                            else               cnt_d   = cnt_q - 3'd1;
                        end else if (state_q == ST_BEAT) begin
                            ptr_d = wrap_nxt;
                        end
                    end
                end
                ST_SUSP: begin
                    if (!halt && !oe_n)
                        state_d = susp_lat_q ? ST_LAT : ST_BEAT;
                end
                default: state_d = ST_IDLE;
            endcase
            if (go) begin
                armed_d = 1'b0;
                state_d = info_d ? ST_INFO : ST_LAT;
                cnt_d   = lat_q - 3'd1;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ptr_q      <= '0;
            cnt_q      <= '0;
            armed_q    <= 1'b0;
            susp_lat_q <= 1'b0;
            info_q     <= 1'b0;
            sync_q     <= 1'b0;
            lat_q      <= LAT_RST;
            len_q      <= 2'd0;
        end else begin
            state_q    <= state_d;
            ptr_q      <= ptr_d;
            cnt_q      <= cnt_d;
            armed_q    <= armed_d;
            susp_lat_q <= susp_lat_d;
            info_q     <= info_d;
            if (cfg_load) begin
                sync_q <= cfg_sync;
                lat_q  <= (cfg_lat < 3'd2) ? 3'd2 : cfg_lat;
                len_q  <= cfg_len;
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_LAT:  wait_val = 1'b1;
            ST_SUSP: wait_val = susp_lat_q | info_q;
            default: wait_val = info_q;
        endcase
    end

    // R9
    idle_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> state_q == ST_IDLE);

    // R7
    halt_freezes_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BEAT && halt && !ce_n && !cfg_load) |=> $stable(ptr_q));

    // R8
    suspend_holds_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP && sync_q && !cfg_load) |=> $stable(ptr_q));

    // R8
    resume_leaves_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP && sync_q && !cfg_load && !ce_n && !halt && !oe_n)
        |=> state_q != ST_SUSP);

    // R6
    wrap_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BEAT && sync_q && !cfg_load && !ce_n && adv_n && !halt)
        |=> (ptr_q[AW-1:4] == $past(ptr_q[AW-1:4])) && (ptr_q != $past(ptr_q)));
endmodule

// File: rtl/flash_read_port.sv
module flash_read_port #(
    parameter int            AW      = 8,
    parameter int            DW      = 16,
    parameter logic [15:0]   ID_CODE = 16'h89C0,
    parameter logic [2:0]    LAT_RST = 3'd4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          adv_n,
    input  logic          clk_halt,
    input  logic          info_sel,
    input  logic [AW-1:0] addr,
    input  logic          cfg_load,
    input  logic          cfg_sync,
    input  logic [2:0]    cfg_lat,
    input  logic [1:0]    cfg_len,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          wait_out,
    output logic          wait_oe
);
    logic [AW-1:0] ptr_d;
    logic [AW-1:0] ptr_q;
    logic          info_q;
    logic          wait_val;
    logic [DW-1:0] rd_data;

    burst_ctrl #(.AW(AW), .LAT_RST(LAT_RST)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .adv_n    (adv_n),
        .halt     (clk_halt),
        .info_sel (info_sel),
        .addr     (addr),
        .cfg_load (cfg_load),
        .cfg_sync (cfg_sync),
        .cfg_lat  (cfg_lat),
        .cfg_len  (cfg_len),
        .ptr_d    (ptr_d),
        .ptr_q    (ptr_q),
        .info_q   (info_q),
        .wait_val (wait_val)
    );

    flash_array #(.AW(AW), .DW(DW)) array_i (
        .clk     (clk),
        .rd_addr (ptr_d),
        .rd_data (rd_data)
    );

    always_comb begin
        dq_out   = info_q ? (DW'(ID_CODE) ^ DW'(ptr_q[3:0])) : rd_data;
        dq_oe    = !ce_n && !oe_n && we_n && rst_n;
        wait_oe  = !ce_n;
        wait_out = wait_val;
    end

    // R10
    data_needs_wait_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> wait_oe);
endmodule

// File: tb/flash_read_port_tb_top.sv
module flash_read_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, ce_n, oe_n, we_n, adv_n, clk_halt, info_sel;
    logic [7:0]  addr;
    logic        cfg_load, cfg_sync;
    logic [2:0]  cfg_lat;
    logic [1:0]  cfg_len;
    logic [15:0] dq_out;
    logic        dq_oe, wait_out, wait_oe;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    flash_read_port dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .adv_n(adv_n), .clk_halt(clk_halt), .info_sel(info_sel), .addr(addr),
        .cfg_load(cfg_load), .cfg_sync(cfg_sync), .cfg_lat(cfg_lat),
        .cfg_len(cfg_len), .dq_out(dq_out), .dq_oe(dq_oe),
        .wait_out(wait_out), .wait_oe(wait_oe)
    );

    function automatic logic [15:0] fval(input int a);
        logic [31:0] p;
        p = 32'(a) * 32'd40503;
        return p[15:0] ^ 16'h5A5A;
    endfunction

    function automatic int wrap_addr(input int a, input int n, input int k);
        return (a & ~(n - 1)) | ((a + k) & (n - 1));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic configure(input logic sync, input logic [2:0] lat, input logic [1:0] len);
        cfg_load = 1'b1; cfg_sync = sync; cfg_lat = lat; cfg_len = len;
        cyc();
        cfg_load = 1'b0;
    endtask

    task automatic standby();
        ce_n = 1'b1;
        #1;
        chk("R9 dq_oe in standby", 32'(dq_oe), 0);
        chk("R9 wait_oe in standby", 32'(wait_oe), 0);
        cyc();
        ce_n = 1'b0;
    endtask

    // capture, then check latency and the wrap order
    task automatic burst(input int a, input int lat, input int n, input int beats);
        adv_n = 1'b0; addr = 8'(a);
        cyc();
        chk("R5 wait after capture", 32'(wait_out), 1);
        adv_n = 1'b1; addr = 8'hFF;
        for (int i = 1; i < lat - 1; i++) begin
            cyc();
            chk("R5 wait during latency", 32'(wait_out), 1);
        end
        for (int k = 0; k < beats; k++) begin
            cyc();
            chk("R5 wait during beats", 32'(wait_out), 0);
            chk("R6 burst word", 32'(dq_out), 32'(fval(wrap_addr(a, n, k))));
        end
    endtask

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; adv_n = 1'b1;
        clk_halt = 1'b0; info_sel = 1'b0; addr = '0;
        cfg_load = 1'b0; cfg_sync = 1'b0; cfg_lat = 3'd4; cfg_len = 2'd0;
        cyc(); cyc();
        chk("R9 dq_oe during reset", 32'(dq_oe), 0);
        chk("R10 wait_oe during reset", 32'(wait_oe), 0);
        rst_n = 1'b1;
        cyc();

        // asynchronous reads
        ce_n = 1'b0; adv_n = 1'b0; addr = 8'h13;
        cyc();
        chk("R2 async word", 32'(dq_out), 32'(fval(8'h13)));
        chk("R1 async wait", 32'(wait_out), 0);
        chk("R10 dq_oe active", 32'(dq_oe), 1);
        adv_n = 1'b1; addr = 8'h77;
        cyc(); cyc();
        chk("R2 late address ignored", 32'(dq_out), 32'(fval(8'h13)));
        adv_n = 1'b0;
        cyc();
        chk("R3 array content", 32'(dq_out), 32'(fval(8'h77)));
        adv_n = 1'b1;
        for (int i = 0; i < 4; i++) cyc();
        chk("R1 no burst advance in async", 32'(dq_out), 32'(fval(8'h77)));
        we_n = 1'b0;
        #1;
        chk("R10 we_n blocks data", 32'(dq_oe), 0);
        chk("R10 wait_oe from ce only", 32'(wait_oe), 1);
        we_n = 1'b1;
        oe_n = 1'b1;
        #1;
        chk("R10 oe_n blocks data", 32'(dq_oe), 0);
        oe_n = 1'b0;
        standby();

        // synchronous bursts
        configure(1'b1, 3'd3, 2'd0);
        burst(8'h26, 3, 4, 6);
        standby();
        configure(1'b1, 3'd2, 2'd1);
        burst(8'h3D, 2, 8, 10);
        standby();
        configure(1'b1, 3'd7, 2'd2);
        burst(8'h4E, 7, 16, 18);
        standby();
        configure(1'b1, 3'd1, 2'd0);
        burst(8'h91, 2, 4, 5);     // R12 latency clamp to 2
        standby();

        // halt with outputs enabled, then suspend after data
        configure(1'b1, 3'd2, 2'd1);
        burst(8'h50, 2, 8, 1);
        clk_halt = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R7 halted word held", 32'(dq_out), 32'(fval(8'h50)));
        end
        clk_halt = 1'b0;
        cyc();
        chk("R7 advance after halt", 32'(dq_out), 32'(fval(8'h51)));
        clk_halt = 1'b1; oe_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R8 data released", 32'(dq_oe), 0);
            chk("R8 wait still driven", 32'(wait_oe), 1);
            chk("R8 wait held low", 32'(wait_out), 0);
        end
        clk_halt = 1'b0; oe_n = 1'b0;
        cyc();
        chk("R8 resume same word", 32'(dq_out), 32'(fval(8'h51)));
        cyc();
        chk("R8 resume advance", 32'(dq_out), 32'(fval(8'h52)));
        standby();

        // suspend during latency
        configure(1'b1, 3'd5, 2'd0);
        adv_n = 1'b0; addr = 8'h60;
        cyc();
        adv_n = 1'b1; clk_halt = 1'b1; oe_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R8 wait high in latency suspend", 32'(wait_out), 1);
            chk("R8 wait_oe in latency suspend", 32'(wait_oe), 1);
        end
        clk_halt = 1'b0; oe_n = 1'b0;
        cyc();
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R5 latency after resume", 32'(wait_out), 1);
        end
        cyc();
        chk("R8 first word after resume", 32'(dq_out), 32'(fval(8'h60)));
        chk("R5 wait low at first word", 32'(wait_out), 0);
        standby();

        // capture at adv_n rise while halted
        configure(1'b1, 3'd2, 2'd0);
        clk_halt = 1'b1; adv_n = 1'b0; addr = 8'h71;
        cyc(); cyc();
        adv_n = 1'b1; addr = 8'h99;
        cyc();
        chk("R4 wait after rise capture", 32'(wait_out), 1);
        clk_halt = 1'b0;
        cyc();
        chk("R4 rise-captured word", 32'(dq_out), 32'(fval(8'h71)));
        cyc();
        chk("R4 next word", 32'(dq_out), 32'(fval(8'h72)));
        standby();

        // identifier read
        adv_n = 1'b0; info_sel = 1'b1; addr = 8'h2B;
        cyc();
        chk("R11 info word", 32'(dq_out), 32'(16'h89C0 ^ 16'h000B));
        chk("R11 info wait", 32'(wait_out), 1);
        adv_n = 1'b1; info_sel = 1'b0;
        for (int i = 0; i < 3; i++) cyc();
        chk("R11 info no advance", 32'(dq_out), 32'(16'h89C0 ^ 16'h000B));
        chk("R11 info wait held", 32'(wait_out), 1);
        standby();

        // reset returns to asynchronous mode
        rst_n = 1'b0;
        #1;
        chk("R10 dq_oe under reset", 32'(dq_oe), 0);
        cyc();
        rst_n = 1'b1;
        adv_n = 1'b0; addr = 8'h33;
        cyc();
        chk("R1 async after reset", 32'(dq_out), 32'(fval(8'h33)));
        chk("R1 wait low after reset", 32'(wait_out), 0);
        adv_n = 1'b1;
        for (int i = 0; i < 3; i++) cyc();
        chk("R1 word held after reset", 32'(dq_out), 32'(fval(8'h33)));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule